// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Block

This block is the register file and control state for an address translation unit that sits between a bus master and memory. Software uses a 32-bit register bus to switch translation on or off and to set the page-table base. It can ask the traffic path to stall, and it reads back whether that stall has actually taken hold. It can also invalidate cached translations, either all of them or one 4 KB page. The block sends a single-cycle flush strobe toward the TLB for each of these commands. The translation datapath and the TLB are not part of this block.

The translation datapath reports faults as one-cycle events, each with a 3-bit kind and the address that faulted. Each event sets a sticky bit in an interrupt status register and raises the interrupt line. It stores the address in a capture register chosen by the fault kind. It also forces the unit into the stalled state, where it stays until software turns translation back on. Two prefetch windows, each a start/end pair, are held as plain registers for the datapath. Each end register holds the last address of its window, inclusive.

Top module: `xmmu_regblk`

## Requirements
- R1: After a synchronous active-low reset, translation is off, all writable registers are zero, the interrupt status is zero and `irq` is low.
- R2: Writing 0x5 to the control register (offset 0x000) turns translation on. Writing 0x7 requests the stall, and writing 0x0 turns the unit off. Any other value leaves the mode unchanged. Control reads back 0x5, 0x7 or 0x0 for on, stalled and off.
- R3: Status (offset 0x008) bit 0 reads 1 only while the stall is requested and `path_drained` is high. All other status bits read 0.
- R4: A fault event of kind n sets interrupt status (offset 0x018) bit n on the next clock. The kinds are 0 page miss, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read permission, 6 write security, 7 write permission. Status bits stay set until cleared, and `irq` is the OR of all status bits.
- R5: Writing a mask to the interrupt clear register (offset 0x01C) clears every status bit set in the mask. A fault arriving in the same cycle keeps its bit set.
- R6: Every fault event puts the unit in the stalled state on the next clock, even if a control write occurs in the same cycle. The unit stays stalled until 0x5 is written again.
- R7: The faulting address is stored by kind. Kind 0 goes to 0x024. Kinds 2, 6 and 7 go to 0x028. Kinds 1, 4 and 5 go to 0x02C. Kind 3 goes to 0x030.
- R8: Writing the flush register (offset 0x00C) with bit 0 set gives a one-cycle `tlb_flush_all` pulse on the next clock. If bit 0 is clear, no pulse occurs.
- R9: Writing the single-page flush register (offset 0x010) with bit 0 set gives a one-cycle `tlb_flush_one` pulse on the next clock. At the same time `tlb_flush_page` carries data bits [31:12].
- R10: The page-table base (offset 0x014) and the configuration word (offset 0x004) read back what was written, and `pt_base` follows the page-table base register.
- R11: The prefetch window registers read back what was written. Window 0 start and end are at 0x04C and 0x050, and window 1 at 0x054 and 0x058. Each end value is the window's inclusive last address.
- R12: The version register (offset 0x034) reads 0x3000_0000, with bits [31:28] equal to 3. Writes to status, interrupt status and version have no effect. The flush registers, the clear register and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| flt_valid | input | 1 | Fault event strobe |
| flt_type | input | 3 | Fault kind |
| flt_addr | input | 32 | Faulting address |
| path_drained | input | 1 | Traffic path has no transaction in flight |
| xlat_en | output | 1 | Translation on (running or stalled) |
| stall_req | output | 1 | Stall request toward the traffic path |
| irq | output | 1 | Fault interrupt |
| pt_base | output | 32 | Page-table base |
| tlb_flush_all | output | 1 | Invalidate whole TLB, one-cycle pulse |
| tlb_flush_one | output | 1 | Invalidate one page, one-cycle pulse |
| tlb_flush_page | output | 20 | Page number for `tlb_flush_one` |

## Verification
The embedded assertions check the cycle-to-cycle rules on every clock:
- a fault forces the stall on the next clock,
- a clean 0x5 write resumes translation,
- an unknown control value is ignored,
- each fault sets its sticky bit,
- a clear with no colliding fault removes its bits,
- the flush pulses follow their writes,
- the page-table base takes the written value,
- the drained flag is never reported without a stall request.

The bench scenarios are needed for the rest:
- the fault-kind to capture-register mapping,
- a same-cycle clear and fault on one bit,
- a fault colliding with a control write,
- the read-only registers surviving writes,
- the full offset map, including unmapped offsets.

// File: rtl/xmmu_pkg.sv
// Shared constants, types and helpers for the translation-unit register block.
// Assumes byte offsets on an 8-bit register address and 32-bit data.
package xmmu_pkg;
    localparam int REG_AW     = 8;
    localparam int DW         = 32;
    localparam int NUM_FLT    = 8;
    localparam int FLT_TW     = $clog2(NUM_FLT);
    localparam int NUM_SLOT   = 4;
    localparam int PAGE_SHIFT = 12;
    localparam int PAGE_W     = DW - PAGE_SHIFT;

    localparam logic [REG_AW-1:0] OFF_CTRL  = 8'h00;
    localparam logic [REG_AW-1:0] OFF_CFG   = 8'h04;
    localparam logic [REG_AW-1:0] OFF_STAT  = 8'h08;
    localparam logic [REG_AW-1:0] OFF_FLALL = 8'h0C;
    localparam logic [REG_AW-1:0] OFF_FLONE = 8'h10;
    localparam logic [REG_AW-1:0] OFF_PTB   = 8'h14;
    localparam logic [REG_AW-1:0] OFF_IST   = 8'h18;
    localparam logic [REG_AW-1:0] OFF_ICLR  = 8'h1C;
    localparam logic [REG_AW-1:0] OFF_CPF   = 8'h24;
    localparam logic [REG_AW-1:0] OFF_CWR   = 8'h28;
    localparam logic [REG_AW-1:0] OFF_CRD   = 8'h2C;
    localparam logic [REG_AW-1:0] OFF_CDS   = 8'h30;
    localparam logic [REG_AW-1:0] OFF_VER   = 8'h34;
    localparam logic [REG_AW-1:0] OFF_PF0   = 8'h4C;

    localparam logic [DW-1:0] CTRL_OFF = 32'h0;
    localparam logic [DW-1:0] CTRL_ON  = 32'h5;
    localparam logic [DW-1:0] CTRL_BLK = 32'h7;

    // Capture slot indices
    localparam int SLOT_PF = 0;
    localparam int SLOT_RD = 1;
    localparam int SLOT_WR = 2;
    localparam int SLOT_DS = 3;

    typedef enum logic [1:0] {MODE_OFF, MODE_ON, MODE_BLK} mode_e;

    // Maps a fault kind to the capture slot that records its address.
    function automatic int slot_of(input logic [FLT_TW-1:0] kind);
        case (kind)
            3'd0:                 return SLOT_PF;
            3'd3:                 return SLOT_DS;
            3'd1, 3'd4, 3'd5:     return SLOT_RD;
            default:              return SLOT_WR;
        endcase
    endfunction
endpackage

// File: rtl/xmmu_mode_fsm.sv
// Operating-mode state: off, translating, or stalled.
// Assumes the decoded control write strobe and raw write value; faults
// override software and force the stall.
module xmmu_mode_fsm
    import xmmu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] ctrl_val,
    input  logic          flt_valid,
    output logic          xlat_en,
    output logic          stall_req,
    output logic [DW-1:0] ctrl_rd
);
    mode_e mode_q, mode_d;

    // Next mode: software command first, then fault override.
    always_comb begin
        mode_d = mode_q;
        if (ctrl_wr) begin
            case (ctrl_val)
                CTRL_ON:  mode_d = MODE_ON;
                CTRL_BLK: mode_d = MODE_BLK;
                CTRL_OFF: mode_d = MODE_OFF;
                default:  mode_d = mode_q;
            endcase
        end
        if (flt_valid) mode_d = MODE_BLK;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_d;
    end

    // Decode mode to outputs and control readback.
    always_comb begin
        xlat_en   = (mode_q != MODE_OFF);
        stall_req = (mode_q == MODE_BLK);
        case (mode_q)
            MODE_ON:  ctrl_rd = CTRL_ON;
            MODE_BLK: ctrl_rd = CTRL_BLK;
            default:  ctrl_rd = CTRL_OFF;
        endcase
    end

    // R6
    fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> stall_req);

    // R2
    ctrl_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_val == CTRL_ON && !flt_valid) |=> (xlat_en && !stall_req));

    // R2
    ctrl_bad_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_val != CTRL_ON && ctrl_val != CTRL_BLK &&
         ctrl_val != CTRL_OFF && !flt_valid) |=> $stable(ctrl_rd));
endmodule

// File: rtl/xmmu_fault_log.sv
// Sticky fault status bits, interrupt line and per-kind address capture.
// Assumes at most one fault event per cycle; a clear never beats a fault.
module xmmu_fault_log
    import xmmu_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flt_valid,
    input  logic [FLT_TW-1:0]              flt_type,
    input  logic [DW-1:0]                  flt_addr,
    input  logic                           clr_wr,
    input  logic [NUM_FLT-1:0]             clr_mask,
    output logic [NUM_FLT-1:0]             ist,
    output logic                           irq,
    output logic [NUM_SLOT-1:0][DW-1:0]    cap
);
    logic [NUM_FLT-1:0] ist_q;
    logic [NUM_FLT-1:0] set_vec, clr_vec;

    // Set and clear vectors for this cycle.
    always_comb begin
        set_vec = flt_valid ? (NUM_FLT'(1) << flt_type) : '0;
        clr_vec = clr_wr ? clr_mask : '0;
    end

    // Sticky status: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ist_q <= '0;
        else        ist_q <= (ist_q & ~clr_vec) | set_vec;
    end

    assign ist = ist_q;
    assign irq = |ist_q;

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_cap
        logic [DW-1:0] addr_q;
        // Latch the faulting address when the kind maps to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                               addr_q <= '0;
            else if (flt_valid && slot_of(flt_type) == s) addr_q <= flt_addr;
        end
        assign cap[s] = addr_q;
    end

    // R4
    fault_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> ist_q[$past(flt_type)]);

    // R5
    clear_drops_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !flt_valid) |=> ((ist_q & $past(clr_mask)) == '0));

    // R7
    page_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_type == '0) |=> (cap[SLOT_PF] == $past(flt_addr)));
endmodule

// File: rtl/xmmu_pf_regs.sv
// Prefetch window start/end register pairs.
// Assumes entries are laid out start, end, start, end ... at 4-byte steps.
module xmmu_pf_regs
    import xmmu_pkg::*;
#(
    parameter int NUM_PF = 2,
    localparam int NE    = 2 * NUM_PF
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [REG_AW-1:0]        addr,
    input  logic [DW-1:0]            wdata,
    output logic [NE-1:0][DW-1:0]    ent
);
    for (genvar e = 0; e < NE; e++) begin : g_ent
        localparam logic [REG_AW-1:0] MY_OFF = REG_AW'(OFF_PF0 + 4 * e);
        logic [DW-1:0] val_q;
        // Store a write addressed to this entry.
        always_ff @(posedge clk) begin
            if (!rst_n)                    val_q <= '0;
            else if (wr && addr == MY_OFF) val_q <= wdata;
        end
        assign ent[e] = val_q;
    end
endmodule

// File: rtl/xmmu_regblk.sv
// Top of the translation-unit control and fault register block: address
// decode, config and table base, flush strobes and the read mux.
// Assumes single-cycle writes; reads are combinational on reg_addr.
module xmmu_regblk
    import xmmu_pkg::*;
#(
    parameter int NUM_PF    = 2,
    parameter int VER_MAJOR = 3
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [7:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                flt_valid,
    input  logic [2:0]          flt_type,
    input  logic [31:0]         flt_addr,
    input  logic                path_drained,
    output logic                xlat_en,
    output logic                stall_req,
    output logic                irq,
    output logic [31:0]         pt_base,
    output logic                tlb_flush_all,
    output logic                tlb_flush_one,
    output logic [19:0]         tlb_flush_page
);
    localparam int NE = 2 * NUM_PF;
    localparam logic [DW-1:0] VER_WORD = {4'(VER_MAJOR), 28'h0};

    logic [DW-1:0]                 ctrl_rd;
    logic [NUM_FLT-1:0]            ist;
    logic [NUM_SLOT-1:0][DW-1:0]   cap;
    logic [NE-1:0][DW-1:0]         pf_ent;
    logic [DW-1:0]                 cfg_q, ptb_q;
    logic                          fl_all_q, fl_one_q;
    logic [PAGE_W-1:0]             fl_page_q;
    logic                          blocked;

    xmmu_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (reg_wr && reg_addr == OFF_CTRL),
        .ctrl_val  (reg_wdata),
        .flt_valid (flt_valid),
        .xlat_en   (xlat_en),
        .stall_req (stall_req),
        .ctrl_rd   (ctrl_rd)
    );

    xmmu_fault_log u_flog (
        .clk       (clk),
        .rst_n     (rst_n),
        .flt_valid (flt_valid),
        .flt_type  (flt_type),
        .flt_addr  (flt_addr),
        .clr_wr    (reg_wr && reg_addr == OFF_ICLR),
        .clr_mask  (reg_wdata[NUM_FLT-1:0]),
        .ist       (ist),
        .irq       (irq),
        .cap       (cap)
    );

    xmmu_pf_regs #(.NUM_PF(NUM_PF)) u_pf (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .ent   (pf_ent)
    );

    // Configuration word and page-table base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            ptb_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFF_CFG) cfg_q <= reg_wdata;
            if (reg_addr == OFF_PTB) ptb_q <= reg_wdata;
        end
    end

    // One-cycle flush strobes toward the TLB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_all_q  <= 1'b0;
            fl_one_q  <= 1'b0;
            fl_page_q <= '0;
        end else begin
            fl_all_q <= reg_wr && reg_addr == OFF_FLALL && reg_wdata[0];
            fl_one_q <= reg_wr && reg_addr == OFF_FLONE && reg_wdata[0];
            if (reg_wr && reg_addr == OFF_FLONE && reg_wdata[0])
                fl_page_q <= reg_wdata[DW-1:PAGE_SHIFT];
        end
    end

    assign pt_base        = ptb_q;
    assign tlb_flush_all  = fl_all_q;
    assign tlb_flush_one  = fl_one_q;
    assign tlb_flush_page = fl_page_q;
    assign blocked        = stall_req && path_drained;

    // Read mux over the register map.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTRL: reg_rdata = ctrl_rd;
            OFF_CFG:  reg_rdata = cfg_q;
            OFF_STAT: reg_rdata = {{(DW-1){1'b0}}, blocked};
            OFF_PTB:  reg_rdata = ptb_q;
            OFF_IST:  reg_rdata = {{(DW-NUM_FLT){1'b0}}, ist};
            OFF_CPF:  reg_rdata = cap[SLOT_PF];
            OFF_CWR:  reg_rdata = cap[SLOT_WR];
            OFF_CRD:  reg_rdata = cap[SLOT_RD];
            OFF_CDS:  reg_rdata = cap[SLOT_DS];
            OFF_VER:  reg_rdata = VER_WORD;
            default: begin
                for (int e = 0; e < NE; e++)
                    if (reg_addr == REG_AW'(OFF_PF0 + 4 * e)) reg_rdata = pf_ent[e];
            end
        endcase
    end

    // R8
    flush_all_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_FLALL && reg_wdata[0]) |=> tlb_flush_all);

    // R9
    flush_one_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_FLONE && reg_wdata[0]) |=>
        (tlb_flush_one && tlb_flush_page == $past(reg_wdata[31:12])));

    // R10
    ptbase_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_PTB) |=> (pt_base == $past(reg_wdata)));

    // R3
    status_needs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_STAT && !stall_req) |-> (reg_rdata == '0));
endmodule

// File: tb/xmmu_regblk_tb.sv
`timescale 1ns/1ps
module xmmu_regblk_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        flt_valid = 1'b0;
    logic [2:0]  flt_type = '0;
    logic [31:0] flt_addr = '0;
    logic        path_drained = 1'b0;
    logic        xlat_en, stall_req, irq, tlb_flush_all, tlb_flush_one;
    logic [31:0] pt_base;
    logic [19:0] tlb_flush_page;

    int total = 0;
    int bad   = 0;
    bit run   = 1'b0;

    always #2.5 clk = ~clk;

    xmmu_regblk u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_valid(flt_valid),
        .flt_type(flt_type), .flt_addr(flt_addr), .path_drained(path_drained),
        .xlat_en(xlat_en), .stall_req(stall_req), .irq(irq), .pt_base(pt_base),
        .tlb_flush_all(tlb_flush_all), .tlb_flush_one(tlb_flush_one),
        .tlb_flush_page(tlb_flush_page)
    );

    // Behavioural reference model
    logic [31:0] m_mode, m_cfg, m_pt;
    logic [7:0]  m_ist;
    logic [31:0] m_pfa, m_rda, m_wra, m_dsa;
    logic [31:0] m_pf [4];
    logic        m_fa, m_fo;
    logic [19:0] m_page;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cfg = 0; m_pt = 0; m_ist = 0;
            m_pfa = 0; m_rda = 0; m_wra = 0; m_dsa = 0;
            foreach (m_pf[i]) m_pf[i] = 0;
            m_fa = 0; m_fo = 0; m_page = 0;
        end else begin
            m_fa = 0; m_fo = 0;
            if (reg_wr) begin
                if (reg_addr == 8'h00 && (reg_wdata == 5 || reg_wdata == 7 || reg_wdata == 0))
                    m_mode = reg_wdata;
                if (reg_addr == 8'h04) m_cfg = reg_wdata;
                if (reg_addr == 8'h14) m_pt = reg_wdata;
                if (reg_addr == 8'h1C) m_ist = m_ist & ~reg_wdata[7:0];
                if (reg_addr == 8'h0C && reg_wdata[0]) m_fa = 1;
                if (reg_addr == 8'h10 && reg_wdata[0]) begin m_fo = 1; m_page = reg_wdata[31:12]; end
                for (int i = 0; i < 4; i++) if (reg_addr == 8'h4C + 4*i) m_pf[i] = reg_wdata;
            end
            if (flt_valid) begin
                m_mode = 7;
                m_ist[flt_type] = 1'b1;
                if (flt_type == 0) m_pfa = flt_addr;
                else if (flt_type == 3) m_dsa = flt_addr;
                else if (flt_type == 1 || flt_type == 4 || flt_type == 5) m_rda = flt_addr;
                else m_wra = flt_addr;
            end
        end
    end

    function automatic logic [31:0] mread(input logic [7:0] a);
        case (a)
            8'h00: return m_mode;
            8'h04: return m_cfg;
            8'h08: return {31'b0, (m_mode == 7) && path_drained};
            8'h14: return m_pt;
            8'h18: return {24'b0, m_ist};
            8'h24: return m_pfa;
            8'h28: return m_wra;
            8'h2C: return m_rda;
            8'h30: return m_dsa;
            8'h34: return 32'h3000_0000;
            8'h4C: return m_pf[0];
            8'h50: return m_pf[1];
            8'h54: return m_pf[2];
            8'h58: return m_pf[3];
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of registered outputs against the model.
    always @(negedge clk) begin
        if (run) begin
            chk("R2 xlat_en", {31'b0, xlat_en}, {31'b0, m_mode != 0});
            chk("R6 stall_req", {31'b0, stall_req}, {31'b0, m_mode == 7});
            chk("R4 irq", {31'b0, irq}, {31'b0, m_ist != 0});
            chk("R10 pt_base", pt_base, m_pt);
            chk("R8 flush_all", {31'b0, tlb_flush_all}, {31'b0, m_fa});
            chk("R9 flush_one", {31'b0, tlb_flush_one}, {31'b0, m_fo});
            if (m_fo) chk("R9 page", {12'b0, tlb_flush_page}, {12'b0, m_page});
        end
    end

    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic fv, input logic [2:0] ft, input logic [31:0] fa);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d;
        flt_valid = fv; flt_type = ft; flt_addr = fa;
        @(negedge clk);
        reg_wr = 1'b0; flt_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 3'd0, 32'h0);
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic sweep();
        for (int a = 0; a <= 8'h5C; a += 4) begin
            @(negedge clk);
            reg_addr = 8'(a);
            #1;
            chk("R12 map", reg_rdata, mread(8'(a)));
        end
    endtask

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run = 1'b1;

        // R1 reset state
        rd("R1 ctrl", 8'h00, 32'h0);
        rd("R1 ist", 8'h18, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd("R12 version", 8'h34, 32'h3000_0000);
        sweep();

        // R2 control values
        wr(8'h00, 32'h5);
        rd("R2 on", 8'h00, 32'h5);
        wr(8'h00, 32'h3);
        rd("R2 ignore", 8'h00, 32'h5);
        wr(8'h00, 32'h7);
        rd("R2 block", 8'h00, 32'h7);
        // R3 drained handshake
        rd("R3 not drained", 8'h08, 32'h0);
        path_drained = 1'b1;
        rd("R3 drained", 8'h08, 32'h1);
        wr(8'h00, 32'h5);
        rd("R3 unblocked", 8'h08, 32'h0);
        wr(8'h00, 32'h0);
        rd("R2 off", 8'h00, 32'h0);

        // R4/R7 every fault kind
        for (int t = 0; t < 8; t++)
            cyc(1'b0, 8'h00, 32'h0, 1'b1, 3'(t), 32'h1000_0000 + 32'(t) * 32'h111);
        rd("R4 all bits", 8'h18, 32'hFF);
        rd("R7 page", 8'h24, 32'h1000_0000);
        rd("R7 read", 8'h2C, 32'h1000_0555);
        rd("R7 write", 8'h28, 32'h1000_0777);
        rd("R7 bus", 8'h30, 32'h1000_0333);
        rd("R6 blocked", 8'h00, 32'h7);

        // R5 clear
        wr(8'h1C, 32'h0F);
        rd("R5 partial", 8'h18, 32'hF0);
        cyc(1'b1, 8'h1C, 32'h10, 1'b1, 3'd4, 32'hABCD_0000);
        rd("R5 set wins", 8'h18, 32'hF0);
        wr(8'h1C, 32'hFF);
        rd("R5 all clear", 8'h18, 32'h0);
        chk("R5 irq low", {31'b0, irq}, 32'h0);

        // R6 fault vs control write
        wr(8'h00, 32'h5);
        cyc(1'b1, 8'h00, 32'h5, 1'b1, 3'd6, 32'h2222_0000);
        rd("R6 fault beats write", 8'h00, 32'h7);
        wr(8'h00, 32'h5);
        rd("R6 resume", 8'h00, 32'h5);
        wr(8'h1C, 32'hFF);

        // R8 flush all
        @(negedge clk); reg_wr = 1; reg_addr = 8'h0C; reg_wdata = 32'h1;
        @(negedge clk); reg_wr = 0; #1;
        chk("R8 pulse", {31'b0, tlb_flush_all}, 32'h1);
        @(negedge clk); #1;
        chk("R8 one cycle", {31'b0, tlb_flush_all}, 32'h0);
        wr(8'h0C, 32'h2);
        #1 chk("R8 bit0 clear", {31'b0, tlb_flush_all}, 32'h0);

        // R9 flush one page
        @(negedge clk); reg_wr = 1; reg_addr = 8'h10; reg_wdata = 32'h89AB_C001;
        @(negedge clk); reg_wr = 0; #1;
        chk("R9 pulse", {31'b0, tlb_flush_one}, 32'h1);
        chk("R9 page", {12'b0, tlb_flush_page}, 32'h89ABC);
        @(negedge clk); #1;
        chk("R9 one cycle", {31'b0, tlb_flush_one}, 32'h0);

        // R10 table base and config
        wr(8'h14, 32'h8765_4000);
        rd("R10 ptb", 8'h14, 32'h8765_4000);
        chk("R10 pt_base", pt_base, 32'h8765_4000);
        wr(8'h04, 32'h1000_1000);
        rd("R10 cfg", 8'h04, 32'h1000_1000);

        // R11 prefetch windows, end = base + size - 1
        wr(8'h4C, 32'h2000_0000);
        wr(8'h50, 32'h2000_0000 + 32'h2_0000 - 1);
        wr(8'h54, 32'h3000_0000);
        wr(8'h58, 32'h3000_0000 + 32'h1_0000 - 1);
        rd("R11 start0", 8'h4C, 32'h2000_0000);
        rd("R11 end0", 8'h50, 32'h2001_FFFF);
        rd("R11 start1", 8'h54, 32'h3000_0000);
        rd("R11 end1", 8'h58, 32'h3000_FFFF);

        // R12 read-only registers ignore writes
        cyc(1'b0, 8'h00, 32'h0, 1'b1, 3'd2, 32'h4444_0000);
        wr(8'h18, 32'h0);
        rd("R12 ist ro", 8'h18, 32'h04);
        wr(8'h34, 32'h0);
        rd("R12 ver ro", 8'h34, 32'h3000_0000);
        wr(8'h08, 32'h0);
        rd("R12 stat ro", 8'h08, 32'h1);
        rd("R12 flush reads 0", 8'h0C, 32'h0);
        sweep();

        run = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule